// File: doc/BRIEF.md
# Transport Stream PID Filter Bank

This block sits on a byte-wide MPEG transport stream made of fixed 188-byte packets. It finds each packet by its 0x47 sync byte. It pulls the 13-bit packet identifier (PID) out of the header and compares it with a small bank of programmable filter slots. Packets that are accepted are forwarded whole, header included, as a stream of 32-bit words. A start-of-packet flag marks the first word, so the stream can go straight into a capture buffer.

Software programs the slots through a one-cycle write port. Each slot has an enable and a PID. The word for slot 0 also carries three global controls:
- forward everything (pass-all),
- forward nothing (block-all),
- the byte order of the output words.

The first three bytes of each packet are held in a short history register. The keep/drop decision is made when the third byte arrives, so nothing from a rejected packet ever leaves the block.

Top module: `ts_pid_gate`

## Requirements
- R1: After reset no word is output, and every slot is disabled with PID 0x1FFF, so no packet is forwarded until a slot or the pass-all control is written.
- R2: A packet whose PID equals the PID of an enabled slot is forwarded as exactly 47 words. The first word has `out_sop` high and the other 46 have it low.
- R3: A packet whose PID matches no enabled slot produces no output word. This includes a slot that holds the same PID but has its enable (bit 15) cleared.
- R4: The PID is taken as bits 4:0 of header byte 1 (upper PID bits) followed by all of header byte 2. Bits 7:5 of byte 1 do not affect the match.
- R5: With pass-all (slot 0 word, bit 16) set, every packet is forwarded whatever its PID.
- R6: With block-all (slot 0 word, bit 13) set, no packet is forwarded, even when pass-all is set or a slot matches.
- R7: With the order bit (slot 0 word, bit 14) clear, the earliest byte of each group of four goes to bits 31:24. With it set, the earliest byte goes to bits 7:0.
- R8: A byte at packet position 0 that is not 0x47 is discarded, and the block keeps hunting. The next 0x47 starts a packet, which is then filtered normally.
- R9: Each output word appears in the cycle after its fourth byte is accepted. Idle input cycles in the middle of a packet only stall the output.
- R10: The keep/drop decision and byte order are fixed when header byte 2 is accepted. A configuration write later in that packet takes effect from the next packet.
- R11: Each of the eight slots, slot 0 included, matches its own programmed PID on its own. Slot writes use `cfg_slot` as the index, with PID in bits 12:0 and enable in bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one slot word |
| cfg_slot | input | 3 | Index of the slot to write |
| cfg_data | input | 32 | Slot word: PID 12:0, enable 15; slot 0 also block-all 13, order 14, pass-all 16 |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Transport stream byte |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 32 | Four packed packet bytes |
| out_sop | output | 1 | Marks the first word of a packet |

## Verification
The hardest case to reach from the ports is a configuration change that lands inside a packet after its decision point. The stimulus writes the write strobe together with byte 10 of a matching packet, disabling the slot. It then expects the full packet and a drop of the following packet with the same PID.

Resynchronisation is reached by feeding a run of non-sync bytes ahead of a packet. Stall behaviour is reached by inserting idle cycles inside a packet, and the cycle of the first word is compared against the cycle in which byte 3 was driven.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int PID_W   = 13;
  localparam int BIT_EN  = 15;
  localparam int BIT_BLK = 13;
  localparam int BIT_ORD = 14;
  localparam int BIT_ALL = 16;
  localparam logic [PID_W-1:0] PID_PARK = 13'h1FFF;

  typedef struct packed {
    logic             en;
    logic [PID_W-1:0] pid;
  } slot_t;
endpackage

// File: rtl/tsf_framer.sv
module tsf_framer #(
  parameter int          PKT_LEN = 188,
  parameter logic [7:0]  SYNC    = 8'h47,
  parameter int          POS_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             acc,
  output logic [POS_W-1:0] pos
);
  // a byte is taken when inside a packet, or when it is a sync byte at position 0
  always_comb acc = in_valid && ((pos != '0) || (in_byte == SYNC));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (acc) begin
      pos <= (pos == POS_W'(PKT_LEN - 1)) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/tsf_slots.sv
module tsf_slots
  import tsf_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [31:0]       cfg_data,
  input  logic [7:0]        hdr_hi,
  input  logic [7:0]        hdr_lo,
  output logic              keep,
  output logic              ord
);
  slot_t            tbl [NSLOT];
  logic             blk_q, all_q, ord_q;
  logic [NSLOT-1:0] hit;
  logic [PID_W-1:0] pid;

  always_comb pid = {hdr_hi[PID_W-9:0], hdr_lo};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[s] <= '{en: 1'b0, pid: PID_PARK};
      end else if (cfg_we && cfg_slot == SLOT_W'(s)) begin
        tbl[s] <= '{en: cfg_data[BIT_EN], pid: cfg_data[PID_W-1:0]};
      end
    end
    assign hit[s] = tbl[s].en && (tbl[s].pid == pid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
      all_q <= 1'b0;
      ord_q <= 1'b0;
    end else if (cfg_we && cfg_slot == '0) begin
      blk_q <= cfg_data[BIT_BLK];
      all_q <= cfg_data[BIT_ALL];
      ord_q <= cfg_data[BIT_ORD];
    end
  end

  // block-all wins over everything, pass-all over slot matches
  always_comb begin
    keep = !blk_q && (all_q || (|hit));
    ord  = ord_q;
  end
endmodule

// File: rtl/tsf_packer.sv
module tsf_packer #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       in_byte,
  input  logic             keep_in,
  input  logic             ord_in,
  output logic [7:0]       last_byte,
  output logic             out_valid,
  output logic [31:0]      out_word,
  output logic             out_sop
);
  localparam int HIST = 3;

  logic [7:0] hist [HIST];
  logic       keep_q, ord_q;
  logic       word_end;

  assign last_byte = hist[HIST-1];
  always_comb word_end = acc && (pos[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else if (acc) begin
      for (int i = 0; i < HIST - 1; i++) hist[i] <= hist[i+1];
      hist[HIST-1] <= in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q <= 1'b0;
      ord_q  <= 1'b0;
    end else if (acc && pos == POS_W'(2)) begin
      keep_q <= keep_in;
      ord_q  <= ord_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= word_end && keep_q;
      out_sop   <= word_end && keep_q && (pos == POS_W'(3));
      if (word_end) begin
        out_word <= ord_q ? {in_byte, hist[2], hist[1], hist[0]}
                          : {hist[0], hist[1], hist[2], in_byte};
      end
    end
  end
endmodule

// File: rtl/ts_pid_gate.sv
module ts_pid_gate #(
  parameter int         NSLOT   = 8,
  parameter int         PKT_LEN = 188,
  parameter logic [7:0] SYNC    = 8'h47,
  localparam int        SLOT_W  = $clog2(NSLOT),
  localparam int        POS_W   = $clog2(PKT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [31:0]       cfg_data,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              out_sop
);
  logic             acc;
  logic [POS_W-1:0] pos;
  logic [7:0]       last_byte;
  logic             keep, ord;

  tsf_framer #(.PKT_LEN(PKT_LEN), .SYNC(SYNC), .POS_W(POS_W)) u_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .acc(acc), .pos(pos)
  );

  tsf_slots #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data), .hdr_hi(last_byte), .hdr_lo(in_byte),
    .keep(keep), .ord(ord)
  );

  tsf_packer #(.POS_W(POS_W)) u_packer (
    .clk(clk), .rst(rst), .acc(acc), .pos(pos), .in_byte(in_byte),
    .keep_in(keep), .ord_in(ord), .last_byte(last_byte),
    .out_valid(out_valid), .out_word(out_word), .out_sop(out_sop)
  );
endmodule

// File: rtl/tsf_gate_chk.sv
module tsf_gate_chk #(
  parameter int WORDS = 47
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_sop
);
  localparam int CW = $clog2(WORDS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (out_valid) cnt <= out_sop ? CW'(1) : cnt + 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !out_valid);

  a_r2_sop_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  a_r2_sop_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> (cnt == '0 || cnt == CW'(WORDS)));

  a_r2_body_in_packet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sop) |-> (cnt != '0 && cnt < CW'(WORDS)));

  a_r9_word_needs_byte: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

bind ts_pid_gate tsf_gate_chk #(.WORDS(PKT_LEN / 4)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sop(out_sop)
);

// File: tb/ts_pid_gate_tb.sv
module ts_pid_gate_tb;
  localparam int WORDS = 47;
  localparam int CAP   = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_slot = '0;
  logic [31:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_sop;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int b3_cyc = 0;

  logic [31:0] got_w [CAP];
  logic        got_s [CAP];
  int          got_c [CAP];
  int          got_n = 0;

  always #10 clk = ~clk;

  ts_pid_gate u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_word(out_word), .out_sop(out_sop)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && got_n < CAP) begin
      got_w[got_n] <= out_word;
      got_s[got_n] <= out_sop;
      got_c[got_n] <= cyc;
      got_n <= got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int i, input logic [12:0] pid,
                                       input logic [2:0] hi, input logic [7:0] seed);
    if (i == 0) return 8'h47;
    if (i == 1) return {hi, pid[12:8]};
    if (i == 2) return pid[7:0];
    return 8'((int'(seed) + i * 13) & 8'hFF);
  endfunction

  function automatic logic [31:0] eword(input int k, input logic [12:0] pid,
                                        input logic [2:0] hi, input logic [7:0] seed,
                                        input bit ord);
    logic [7:0] b0, b1, b2, b3;
    b0 = pbyte(4*k,   pid, hi, seed);
    b1 = pbyte(4*k+1, pid, hi, seed);
    b2 = pbyte(4*k+2, pid, hi, seed);
    b3 = pbyte(4*k+3, pid, hi, seed);
    return ord ? {b3, b2, b1, b0} : {b0, b1, b2, b3};
  endfunction

  task automatic cfg(input int slot, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [12:0] pid, input logic [2:0] hi, input logic [7:0] seed,
                      input bit gap, input bit mid, input int mslot, input logic [31:0] mdata);
    for (int i = 0; i < 188; i++) begin
      @(negedge clk);
      if (gap && (i % 5 == 1)) begin
        in_valid = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = pbyte(i, pid, hi, seed);
      cfg_we   = mid && (i == 10);
      cfg_slot = 3'(mslot);
      cfg_data = mdata;
      if (i == 3) b3_cyc = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_pkt(input string req, input int base, input bit pass,
                            input logic [12:0] pid, input logic [2:0] hi,
                            input logic [7:0] seed, input bit ord);
    int n;
    int badk;
    n = got_n - base;
    chk(n == (pass ? WORDS : 0), req, "word count", n, pass ? WORDS : 0);
    if (pass && n == WORDS) begin
      badk = -1;
      for (int k = 0; k < WORDS; k++) begin
        if (badk < 0 && (got_w[base+k] !== eword(k, pid, hi, seed, ord) ||
                         got_s[base+k] !== (k == 0))) badk = k;
      end
      chk(badk < 0, req, "word content", badk < 0 ? 0 : got_w[base+badk],
          badk < 0 ? 0 : eword(badk, pid, hi, seed, ord));
    end
  endtask

  function automatic logic [12:0] spid(input int s);
    return 13'((s * 1027 + 5) & 13'h1FFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    base = got_n; send(13'h1FFF, 3'd0, 8'h11, 0, 0, 0, 0);
    expect_pkt("R1", base, 0, 13'h1FFF, 3'd0, 8'h11, 0);
    base = got_n; send(13'h0000, 3'd0, 8'h12, 0, 0, 0, 0);
    expect_pkt("R1", base, 0, 13'h0000, 3'd0, 8'h12, 0);

    // R11 program every slot, R2 / R4 matches, R3 misses
    for (int s = 0; s < 8; s++) cfg(s, 32'h8000 | 32'(spid(s)));
    for (int s = 0; s < 8; s++) begin
      base = got_n; send(spid(s), 3'(s), 8'(s * 31), 0, 0, 0, 0);
      expect_pkt("R11", base, 1, spid(s), 3'(s), 8'(s * 31), 0);
      base = got_n; send(spid(s) ^ 13'h0100, 3'd7, 8'(s), 0, 0, 0, 0);
      expect_pkt("R3", base, 0, spid(s) ^ 13'h0100, 3'd7, 8'(s), 0);
    end
    // R4 top bits of byte 1 ignored
    base = got_n; send(spid(5), 3'd7, 8'h5A, 0, 0, 0, 0);
    expect_pkt("R4", base, 1, spid(5), 3'd7, 8'h5A, 0);

    // R3 disabled slot with same PID
    cfg(3, 32'(spid(3)));
    base = got_n; send(spid(3), 3'd0, 8'h33, 0, 0, 0, 0);
    expect_pkt("R3", base, 0, spid(3), 3'd0, 8'h33, 0);

    // R5 pass-all
    cfg(0, 32'h0001_8000 | 32'(spid(0)));
    base = got_n; send(13'h0ABC, 3'd2, 8'h44, 0, 0, 0, 0);
    expect_pkt("R5", base, 1, 13'h0ABC, 3'd2, 8'h44, 0);

    // R6 block-all over pass-all and slot match
    cfg(0, 32'h0001_A000 | 32'(spid(0)));
    base = got_n; send(13'h0ABC, 3'd0, 8'h45, 0, 0, 0, 0);
    expect_pkt("R6", base, 0, 13'h0ABC, 3'd0, 8'h45, 0);
    base = got_n; send(spid(4), 3'd0, 8'h46, 0, 0, 0, 0);
    expect_pkt("R6", base, 0, spid(4), 3'd0, 8'h46, 0);

    // R7 byte order
    cfg(0, 32'h0000_C000 | 32'(spid(0)));
    base = got_n; send(spid(0), 3'd1, 8'h77, 0, 0, 0, 0);
    expect_pkt("R7", base, 1, spid(0), 3'd1, 8'h77, 1);
    cfg(0, 32'h0000_8000 | 32'(spid(0)));
    base = got_n; send(spid(0), 3'd1, 8'h78, 0, 0, 0, 0);
    expect_pkt("R7", base, 1, spid(0), 3'd1, 8'h78, 0);

    // R8 hunt over non-sync bytes
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'(8'h10 + i * 9);
    end
    base = got_n; send(spid(6), 3'd0, 8'h66, 0, 0, 0, 0);
    expect_pkt("R8", base, 1, spid(6), 3'd0, 8'h66, 0);

    // R9 stalls and latency
    base = got_n; send(spid(1), 3'd0, 8'h91, 1, 0, 0, 0);
    expect_pkt("R9", base, 1, spid(1), 3'd0, 8'h91, 0);
    chk(got_c[base] == b3_cyc + 1, "R9", "first word cycle", got_c[base], b3_cyc + 1);

    // R10 mid-packet write applies to the next packet
    base = got_n; send(spid(2), 3'd0, 8'hA2, 0, 1, 2, 32'(spid(2)));
    expect_pkt("R10", base, 1, spid(2), 3'd0, 8'hA2, 0);
    base = got_n; send(spid(2), 3'd0, 8'hA3, 0, 0, 0, 0);
    expect_pkt("R10", base, 0, spid(2), 3'd0, 8'hA3, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule